// File: doc/BRIEF.md
# Firmware Load Stream Engine

A single-stream DMA engine that moves a firmware image from host memory to a device-side sink, one byte at a time, over a valid/ready stream. Software programs a small register file with the base address of a descriptor list, the index of the last valid descriptor, an optional byte limit and a control word, then sets the run bit. The engine walks the list in a ring. From each descriptor it takes the address and length of one buffer and streams that buffer's bytes out in ascending address order.

A descriptor can ask for a completion interrupt when its buffer has been fully sent. With the byte limit enabled, the engine stops moving data once the number of bytes sent since the start reaches the programmed value. This lets a driver send a partial final chunk, and it can let the transfer continue by raising the limit. The run bit that software reads back shows the engine's real activity, not the last value written, so software polls it after each start or stop.

Top module: `cl_stream_dma`

## Requirements
- R1: After reset every register reads 0, and `dout_valid_o`, `irq_o` and `mem_req_o` are low.
- R2: Register 0 (control) keeps the bits under mask 0x00FF_003D and reads them back: stream reset bit 0, completion IRQ enable bit 2, FIFO-error enable bit 3, descriptor-error enable bit 4, limit-change bit 5, stripe bits 17:16, priority bit 18, direction bit 19, stream number bits 23:20. The stripe, priority and direction bits do not change the bytes sent.
- R3: Register 2 (list base, low) keeps bits 31:7 and reads 0 in bits 6:0. Register 3 (list base, high) keeps all 32 bits. Register 4 (buffer length) and register 7 (byte limit) are plain 32-bit storage.
- R4: Descriptor i sits at base + 16*i and holds four 32-bit words: buffer address low, buffer address high, byte length, and flags, where flags bit 0 requests completion status. Register 5 holds the index of the last descriptor.
- R5: Control bit 1 (run) is written to start or stop the engine. It reads 1 only once the engine has left idle, so it still reads 0 right after the write cycle. After run=0 is written, it reads 0 once the engine has stopped.
- R6: Bytes come out in ascending address order from any starting address, with byte lane 0 being the lowest address. Descriptors are used from index 0 up to the last index and then from index 0 again.
- R7: While `dout_valid_o` is high and `dout_ready_i` is low, the output stays valid and its data stays the same.
- R8: When register 6 bit 0 is set, the engine sends exactly as many bytes since the start as register 7 holds and then holds off. Raising register 7 lets the transfer continue from the next byte.
- R9: Status register 1 bit 2 is set when the last byte of a descriptor with flags bit 0 set is sent. Writing 1 to that bit clears it. `irq_o` is high while that bit and control bit 2 are both set.
- R10: A descriptor with byte length 0 sets status bit 4 and stops the engine, so the run bit reads 0. `irq_o` is raised while status bit 4 and control bit 4 are both set. Writing 1 to status bit 4 clears it.
- R11: While control bit 0 (stream reset) is set, the engine is held idle, no byte is offered, and both status bits read 0.
- R12: With run=0 and the control, base, length and last-index registers written to zero, the engine stays idle and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the register at `reg_addr_i` |
| mem_req_o | output | 1 | Memory read request; data returns one cycle later |
| mem_addr_o | output | 64 | Word-aligned byte address of the read |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| dout_valid_o | output | 1 | Output byte valid |
| dout_data_o | output | 8 | Output byte |
| dout_ready_i | input | 1 | Sink ready |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest state to reach is the byte limit landing just after a descriptor has completed, while the ring is about to wrap. The engine must then fetch the next descriptor but hold before its first data read, and it must resume at that descriptor's first byte once the limit is raised. The stimulus places an 11-byte limit exactly at the end of a two-descriptor list whose first buffer starts at an unaligned address. Random backpressure on the sink keeps the stall and the output handshake overlapping. The limit is then raised by three bytes, so the wrap back to descriptor 0 can be seen.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_BREQ, ST_BWAIT, ST_SEND, ST_HOLD
  } eng_state_e;

  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_STS  = 3'd1;
  localparam logic [2:0] A_BLO  = 3'd2;
  localparam logic [2:0] A_BHI  = 3'd3;
  localparam logic [2:0] A_LEN  = 3'd4;
  localparam logic [2:0] A_LAST = 3'd5;
  localparam logic [2:0] A_LCTL = 3'd6;
  localparam logic [2:0] A_LIM  = 3'd7;

  localparam logic [31:0] CTL_KEEP = 32'h00FF_003D;
  localparam int B_SRST = 0;
  localparam int B_RUN  = 1;
  localparam int B_IOCE = 2;
  localparam int B_DEIE = 4;
  localparam int S_IOC  = 2;
  localparam int S_DERR = 4;
endpackage

// File: rtl/cl_regs.sv
module cl_regs
  import cl_pkg::*;
#(
  parameter int LAST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              running_i,
  input  logic              ioc_set_i,
  input  logic              derr_i,
  output logic              srst_o,
  output logic              run_req_o,
  output logic              ioce_o,
  output logic [63:0]       base_o,
  output logic [LAST_W-1:0] last_o,
  output logic              lim_en_o,
  output logic [31:0]       lim_o,
  output logic              irq_o
);
  logic [31:0]       ctl_q, base_hi_q, len_q, lim_q;
  logic [24:0]       base_lo_q;
  logic [LAST_W-1:0] last_q;
  logic              run_q, lim_en_q, ioc_q, derr_q;
  logic              w1c;

  assign w1c = reg_wr_i && (reg_addr_i == A_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0; run_q <= 1'b0; base_lo_q <= '0; base_hi_q <= '0;
      len_q <= '0; last_q <= '0; lim_en_q <= 1'b0; lim_q <= '0;
    end else begin
      if (reg_wr_i) begin
        unique case (reg_addr_i)
          A_CTL: begin
            ctl_q <= reg_wdata_i & CTL_KEEP;
            run_q <= reg_wdata_i[B_RUN];
          end
          A_BLO:  base_lo_q <= reg_wdata_i[31:7];
          A_BHI:  base_hi_q <= reg_wdata_i;
          A_LEN:  len_q     <= reg_wdata_i;
          A_LAST: last_q    <= reg_wdata_i[LAST_W-1:0];
          A_LCTL: lim_en_q  <= reg_wdata_i[0];
          A_LIM:  lim_q     <= reg_wdata_i;
          default: ;
        endcase
      end
      if (derr_i) run_q <= 1'b0;  // a bad descriptor drops the request
    end
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ioc_q <= 1'b0; derr_q <= 1'b0;
    end else if (ctl_q[B_SRST]) begin
      ioc_q <= 1'b0; derr_q <= 1'b0;
    end else begin
      ioc_q  <= ioc_set_i | (ioc_q  & ~(w1c & reg_wdata_i[S_IOC]));
      derr_q <= derr_i    | (derr_q & ~(w1c & reg_wdata_i[S_DERR]));
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTL:   reg_rdata_o = ctl_q | (32'(running_i) << B_RUN);
      A_STS:   reg_rdata_o = (32'(derr_q) << S_DERR) | (32'(ioc_q) << S_IOC);
      A_BLO:   reg_rdata_o = {base_lo_q, 7'd0};
      A_BHI:   reg_rdata_o = base_hi_q;
      A_LEN:   reg_rdata_o = len_q;
      A_LAST:  reg_rdata_o = {{(32-LAST_W){1'b0}}, last_q};
      A_LCTL:  reg_rdata_o = {31'd0, lim_en_q};
      default: reg_rdata_o = lim_q;
    endcase
  end

  assign srst_o    = ctl_q[B_SRST];
  assign run_req_o = run_q;
  assign ioce_o    = ctl_q[B_IOCE];
  assign base_o    = {base_hi_q, base_lo_q, 7'd0};
  assign last_o    = last_q;
  assign lim_en_o  = lim_en_q;
  assign lim_o     = lim_q;
  assign irq_o     = (ioc_q & ctl_q[B_IOCE]) | (derr_q & ctl_q[B_DEIE]);
endmodule

// File: rtl/cl_engine.sv
module cl_engine
  import cl_pkg::*;
#(
  parameter int LAST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              run_req_i,
  input  logic [63:0]       base_i,
  input  logic [LAST_W-1:0] last_i,
  input  logic              lim_en_i,
  input  logic [31:0]       lim_i,
  output logic              mem_req_o,
  output logic [63:0]       mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              dout_valid_o,
  output logic [7:0]        dout_data_o,
  input  logic              dout_ready_i,
  output logic              running_o,
  output logic              ioc_set_o,
  output logic              derr_o
);
  eng_state_e        st_q;
  logic [LAST_W-1:0] idx_q;
  logic [1:0]        k_q;
  logic [63:0]       buf_q, cur_addr;
  logic [31:0]       len_q, boff_q, pos_q, word_q;
  logic              flag_q, go, at_lim, at_lim_nxt, hs, last_byte;

  assign go         = run_req_i && !srst_i;
  assign at_lim     = lim_en_i && (pos_q >= lim_i);
  assign at_lim_nxt = lim_en_i && ((pos_q + 32'd1) >= lim_i);
  assign cur_addr   = buf_q + {32'd0, boff_q};
  assign hs         = (st_q == ST_SEND) && dout_ready_i;
  assign last_byte  = (boff_q + 32'd1) == len_q;

  assign running_o    = st_q != ST_IDLE;
  assign dout_valid_o = st_q == ST_SEND;
  assign dout_data_o  = word_q[{cur_addr[1:0], 3'b000} +: 8];
  assign ioc_set_o    = hs && !srst_i && last_byte && flag_q;
  assign derr_o       = (st_q == ST_DWAIT) && !srst_i && (k_q == 2'd3) && (len_q == '0);
  assign mem_req_o    = go && ((st_q == ST_DREQ) || ((st_q == ST_BREQ) && !at_lim));
  assign mem_addr_o   = (st_q == ST_DREQ)
                      ? base_i + 64'({idx_q, 4'b0000}) + 64'({k_q, 2'b00})
                      : {cur_addr[63:2], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; idx_q <= '0; k_q <= '0; buf_q <= '0; len_q <= '0;
      boff_q <= '0; pos_q <= '0; word_q <= '0; flag_q <= 1'b0;
    end else if (srst_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (run_req_i) begin
          idx_q <= '0; k_q <= '0; pos_q <= '0; st_q <= ST_DREQ;
        end
        ST_DREQ: st_q <= run_req_i ? ST_DWAIT : ST_IDLE;
        ST_DWAIT: begin
          k_q <= k_q + 2'd1;
          unique case (k_q)
            2'd0: buf_q[31:0]  <= mem_rdata_i;
            2'd1: buf_q[63:32] <= mem_rdata_i;
            2'd2: len_q        <= mem_rdata_i;
            default: flag_q    <= mem_rdata_i[0];
          endcase
          if (k_q != 2'd3)        st_q <= ST_DREQ;
          else if (len_q == '0)   st_q <= ST_IDLE;
          else begin
            boff_q <= '0; st_q <= ST_BREQ;
          end
        end
        ST_BREQ: begin
          if (!run_req_i)  st_q <= ST_IDLE;
          else if (at_lim) st_q <= ST_HOLD;
          else             st_q <= ST_BWAIT;
        end
        ST_BWAIT: begin
          word_q <= mem_rdata_i;
          st_q   <= ST_SEND;
        end
        ST_SEND: if (dout_ready_i) begin
          pos_q  <= pos_q + 32'd1;
          boff_q <= boff_q + 32'd1;
          if (last_byte) begin
            idx_q <= (idx_q >= last_i) ? '0 : idx_q + 1'b1;
            k_q   <= '0;
            st_q  <= ST_DREQ;
          end else if (!run_req_i)     st_q <= ST_IDLE;
          else if (at_lim_nxt)         st_q <= ST_HOLD;
          else if (cur_addr[1:0] == 2'd3) st_q <= ST_BREQ;
        end
        ST_HOLD: begin
          if (!run_req_i)  st_q <= ST_IDLE;
          else if (!at_lim) st_q <= ST_BREQ;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cl_stream_dma.sv
module cl_stream_dma
  import cl_pkg::*;
#(
  parameter int LAST_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [63:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  output logic        dout_valid_o,
  output logic [7:0]  dout_data_o,
  input  logic        dout_ready_i,
  output logic        irq_o
);
  logic              srst, run_req, ioce, running, ioc_set, derr, lim_en;
  logic [63:0]       base;
  logic [LAST_W-1:0] last;
  logic [31:0]       lim;

  cl_regs #(.LAST_W(LAST_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .running_i(running), .ioc_set_i(ioc_set), .derr_i(derr),
    .srst_o(srst), .run_req_o(run_req), .ioce_o(ioce), .base_o(base),
    .last_o(last), .lim_en_o(lim_en), .lim_o(lim), .irq_o
  );

  cl_engine #(.LAST_W(LAST_W)) u_engine (
    .clk_i, .rst_ni, .srst_i(srst), .run_req_i(run_req), .base_i(base),
    .last_i(last), .lim_en_i(lim_en), .lim_i(lim),
    .mem_req_o, .mem_addr_o, .mem_rdata_i,
    .dout_valid_o, .dout_data_o, .dout_ready_i,
    .running_o(running), .ioc_set_o(ioc_set), .derr_o(derr)
  );
endmodule

// File: rtl/cl_stream_dma_chk.sv
module cl_stream_dma_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       srst,
  input logic       run_req,
  input logic       running,
  input logic       mem_req_o,
  input logic       dout_valid_o,
  input logic [7:0] dout_data_o,
  input logic       dout_ready_i,
  input logic       derr,
  input logic       ioc_set,
  input logic       ioce,
  input logic       irq_o
);
  a_r7_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_valid_o && !dout_ready_i && !srst) |=> (dout_valid_o && $stable(dout_data_o)));

  a_r12_no_fetch_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> !mem_req_o);

  a_r11_valid_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_valid_o |-> running);

  a_r10_derr_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    derr |=> (!running && !run_req));

  a_r9_ioc_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ioc_set && ioce) |=> irq_o);

  a_r5_run_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running) |-> $past(run_req));
endmodule

bind cl_stream_dma cl_stream_dma_chk u_chk (
  .clk_i, .rst_ni, .srst, .run_req, .running, .mem_req_o, .dout_valid_o,
  .dout_data_o, .dout_ready_i, .derr, .ioc_set, .ioce, .irq_o
);

// File: tb/cl_stream_dma_bench.sv
module cl_stream_dma_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, mem_rdata;
  logic        mem_req, dvalid, dready = 1'b0, irq;
  logic [63:0] mem_addr;
  logic [7:0]  ddata;
  logic [31:0] mem [0:255];
  logic [7:0]  got [0:255];
  int          n_got = 0, n_chk = 0, n_fail = 0, cyc = 0;
  logic        rdy_all = 1'b1;
  logic [7:0]  lfsr = 8'hA5;

  always #10 clk = ~clk;

  cl_stream_dma u_cl_stream_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .dout_valid_o(dvalid),
    .dout_data_o(ddata), .dout_ready_i(dready), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (mem_req) mem_rdata <= mem[mem_addr[9:2]];
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    dready <= rdy_all ? 1'b1 : lfsr[0];
  end

  always @(negedge clk) if (dvalid && dready && n_got < 256) begin
    got[n_got] = ddata;
    n_got++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13) ^ (a >> 3));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_bytes(int n);
    for (int i = 0; i < 2000 && n_got < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bit all_zero = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rreg(3'(a), v);
      if (v != 0) all_zero = 1'b0;
    end
    chk(all_zero, "R1 regs zero", {31'd0, all_zero}, 32'd1);
    chk(!dvalid && !irq && !mem_req, "R1 outputs low",
        {29'd0, dvalid, irq, mem_req}, 32'd0);
  endtask

  task automatic t_fields;
    logic [31:0] v;
    bit req_seen = 1'b0;
    wreg(3'd0, 32'hFFFF_FFFC);
    rreg(3'd0, v); chk(v == 32'h00FF_003C, "R2 control mask", v, 32'h00FF_003C);
    wreg(3'd2, 32'hFFFF_FFFF);
    rreg(3'd2, v); chk(v == 32'hFFFF_FF80, "R3 base low alignment", v, 32'hFFFF_FF80);
    wreg(3'd3, 32'h1234_5678);
    rreg(3'd3, v); chk(v == 32'h1234_5678, "R3 base high", v, 32'h1234_5678);
    wreg(3'd7, 32'hCAFE_0001);
    rreg(3'd7, v); chk(v == 32'hCAFE_0001, "R3 limit storage", v, 32'hCAFE_0001);
    wreg(3'd0, 0); wreg(3'd2, 0); wreg(3'd3, 0); wreg(3'd4, 0); wreg(3'd5, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req || dvalid) req_seen = 1'b1;
    end
    chk(!req_seen, "R12 idle after clear", {31'd0, req_seen}, 32'd0);
    rreg(3'd0, v); chk(v[1] == 1'b0, "R12 run reads 0", v, 32'd0);
  endtask

  task automatic t_stream;
    logic [31:0] v;
    int exp_a [0:13];
    bit bad = 1'b0;
    for (int i = 0; i < 5; i++) exp_a[i] = 'h201 + i;
    for (int i = 0; i < 6; i++) exp_a[5 + i] = 'h240 + i;
    for (int i = 0; i < 3; i++) exp_a[11 + i] = 'h201 + i;
    n_got = 0; rdy_all = 1'b0;
    wreg(3'd2, 0); wreg(3'd3, 0); wreg(3'd5, 1); wreg(3'd4, 11);
    wreg(3'd7, 11); wreg(3'd6, 1);
    wreg(3'd0, 32'h001F_0006);
    rreg(3'd0, v); chk(v == 32'h001F_0004, "R5 run not yet active", v, 32'h001F_0004);
    @(negedge clk);
    rreg(3'd0, v); chk(v == 32'h001F_0006, "R5 run reads active", v, 32'h001F_0006);
    wait_bytes(11);
    for (int i = 0; i < 11; i++)
      if (got[i] != pat(exp_a[i])) begin
        bad = 1'b1;
        chk(1'b0, "R6 R4 R7 byte order", 32'(got[i]), 32'(pat(exp_a[i])));
      end
    chk(!bad && n_got == 11, "R6 R2 eleven bytes in order", n_got, 11);
    repeat (60) @(negedge clk);
    chk(n_got == 11, "R8 stops at limit", n_got, 11);
    rreg(3'd1, v); chk(v == 32'h4, "R9 completion status", v, 32'h4);
    chk(irq == 1'b1, "R9 irq high", {31'd0, irq}, 32'd1);
    wreg(3'd7, 14);
    wait_bytes(14);
    repeat (30) @(negedge clk);
    bad = 1'b0;
    for (int i = 11; i < 14; i++) if (got[i] != pat(exp_a[i])) bad = 1'b1;
    chk(!bad && n_got == 14, "R8 R6 resume after raise and wrap", n_got, 14);
    wreg(3'd1, 32'h4);
    rreg(3'd1, v); chk(v == 0 && !irq, "R9 write one clears", v, 32'd0);
    wreg(3'd0, 32'h001F_0004);
    for (int i = 0; i < 40; i++) begin
      rreg(3'd0, v);
      if (v[1] == 1'b0) break;
      @(negedge clk);
    end
    chk(v[1] == 1'b0, "R5 run reads 0 after stop", v, 32'h001F_0004);
    rdy_all = 1'b1;
  endtask

  task automatic t_zero_len;
    logic [31:0] v;
    wreg(3'd6, 0); wreg(3'd2, 32'h80); wreg(3'd5, 0);
    wreg(3'd0, 32'h12);
    repeat (20) @(negedge clk);
    rreg(3'd1, v); chk(v == 32'h10, "R10 descriptor error status", v, 32'h10);
    rreg(3'd0, v); chk(v == 32'h10, "R10 run dropped", v, 32'h10);
    chk(irq == 1'b1, "R10 irq on error", {31'd0, irq}, 32'd1);
    wreg(3'd1, 32'h10);
    rreg(3'd1, v); chk(v == 0 && !irq, "R10 error cleared", {v[30:0], irq}, 32'd0);
    wreg(3'd0, 0);
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wreg(3'd2, 0); wreg(3'd5, 1);
    wreg(3'd0, 32'h6);
    repeat (70) @(negedge clk);
    rreg(3'd1, v); chk(v == 32'h4, "R11 status set before reset", v, 32'h4);
    wreg(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    rreg(3'd0, v); chk(v == 32'h1, "R11 held idle", v, 32'h1);
    rreg(3'd1, v); chk(v == 0, "R11 status cleared", v, 32'd0);
    chk(!dvalid, "R11 no byte offered", {31'd0, dvalid}, 32'd0);
    wreg(3'd0, 0);
  endtask

  initial begin
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    mem[0] = 32'h201; mem[1] = 0; mem[2] = 5; mem[3] = 0;
    mem[4] = 32'h240; mem[5] = 0; mem[6] = 6; mem[7] = 1;
    mem[32] = 32'h300; mem[33] = 0; mem[34] = 0; mem[35] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fields;
    t_stream;
    t_zero_len;
    t_srst;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule